// File: doc/BRIEF.md
# Clock Frequency Measurement Checker

This block watches several clock domains and judges each one against a slow, always-on
reference clock. In every measured domain a counter counts that clock's own cycles between
consecutive reference edges, so each count covers exactly one reference period. The finished
count returns to the reference domain through a toggle request/acknowledge handshake. There
it is compared with a programmable lower and upper bound. A count under the lower bound sets a
sticky slow flag for that clock, and a count over the upper bound sets a sticky fast flag.

Software controls the block through a simple register port clocked by the reference clock.
The port holds a per-clock enable, a per-clock bound pair, a lock that freezes the enables and
bounds until reset, and the sticky error flags, which are cleared by writing ones. A power
controller drives a per-clock gated input while a measured clock is switched off. No verdict is
formed for a gated clock, and the first window after enable or ungating is thrown away, so a
stopped or restarted clock never raises a spurious error. A clock that is enabled and not gated
but sends no count for a number of reference periods is reported as slow.

Top module: `freqchk_top`

## Requirements
- R1: After reset the enable register (address 0) and the lock register (address 1) read 0. The error register (address 2) and `err_o` read 0. Each bound register (address 4+i) reads lower bound 0 in bits [9:0] and upper bound 1023 in bits [25:16].
- R2: An enabled, ungated clock whose count per reference period lies within its bounds never sets any error flag.
- R3: A completed count above the clock's upper bound sets that clock's fast flag, bit 2i+1 of the error register, and leaves the slow flag, bit 2i, alone.
- R4: A completed count below the clock's lower bound sets that clock's slow flag, bit 2i of the error register.
- R5: Error flags stay set until software writes a 1 to that bit position at address 2. Writing ones clears the flags, and flags written with 0 are kept.
- R6: After a clock is enabled, the partial first window is never compared against the bounds.
- R7: A clock that is enabled and not gated, and that delivers no count within 16 reference cycles, gets its slow flag set and not its fast flag.
- R8: While a clock's gated input is high, and after it is released, stopping and restarting that clock raises no error.
- R9: A disabled clock raises no error, even when it is stopped. After re-enable, a correct clock again raises none.
- R10: Writing 1 to bit 0 of address 1 sets the lock until reset. While locked, writes to the enable and bound registers are ignored, and error clearing still works.
- R11: Each register reads back the last value written to it that was accepted. The enables are bits [N-1:0] of address 0. The bounds for clock i are at address 4+i. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_aon_i | input | 1 | Always-on reference clock; also clocks the register port |
| rst_aon_ni | input | 1 | Asynchronous active-low reset, reference domain |
| clk_meas_i | input | N_CLK | Clocks under measurement |
| rst_meas_ni | input | N_CLK | Asynchronous active-low resets, one per measured domain |
| gated_i | input | N_CLK | High while the corresponding measured clock is switched off |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address for both read and write |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for `addr_i`, combinational |
| err_o | output | 2*N_CLK | Sticky error flags: bit 2i slow, bit 2i+1 fast |

## Verification
A corrupted enable, bound or lock register shows at `rdata_o` in the cycle after the faulty
update, because the bench compares the readback with its model on every reference cycle. A
broken counter, handshake or comparison shows at `err_o` within a few reference periods: a flag
comes up when every clock runs in range, or no flag comes up after a frequency or bound fault
is injected. A bad gating, discard or timeout path also shows at `err_o`, within about 16
reference cycles of a clock stopping or restarting.

// File: rtl/freqchk_pkg.sv
`timescale 1ns/1ps
package freqchk_pkg;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned HI_LSB   = 16;
  localparam int          THR_BASE = 4;

  localparam logic [ADDR_W-1:0] A_EN   = 4'd0;
  localparam logic [ADDR_W-1:0] A_LOCK = 4'd1;
  localparam logic [ADDR_W-1:0] A_ERR  = 4'd2;

  typedef struct packed {
    logic slow;
    logic fast;
  } verdict_t;
endpackage

// File: rtl/freqchk_sync.sv
`timescale 1ns/1ps
module freqchk_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/freqchk_rstsync.sv
`timescale 1ns/1ps
module freqchk_rstsync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] rel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rel_q <= '0;
    else         rel_q <= {rel_q[0], 1'b1};
  end

  assign rst_no = rel_q[1];
endmodule

// File: rtl/freqchk_meas.sv
`timescale 1ns/1ps
// Measured-domain side: counts own cycles between reference edges and
// publishes a finished count through a toggle request.
module freqchk_meas #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_tgl_i,
  input  logic             act_i,
  input  logic             ack_tgl_i,
  output logic             req_tgl_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             ref_s, act_s, ack_s;
  logic             ref_seen_q;
  logic             boundary, idle, res_we;
  logic             first_q, first_d;
  logic [CNT_W-1:0] run_q, run_d;
  logic [CNT_W-1:0] res_q, res_d;
  logic             req_q;

  freqchk_sync #(.WIDTH(3), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ref_tgl_i, act_i, ack_tgl_i}),
    .q_o    ({ref_s, act_s, ack_s})
  );

  always_comb begin
    boundary = ref_s ^ ref_seen_q;
    idle     = (req_q == ack_s);
    res_we   = act_s && boundary && !first_q && idle;

    if (!act_s)        first_d = 1'b1;
    else if (boundary) first_d = 1'b0;
    else               first_d = first_q;

    if (!act_s || boundary)   run_d = '0;
    else if (run_q != CNT_MAX) run_d = run_q + 1'b1;
    else                       run_d = run_q;

    res_d = (run_q == CNT_MAX) ? CNT_MAX : run_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_seen_q <= 1'b0;
      first_q    <= 1'b1;
      run_q      <= '0;
    end else begin
      ref_seen_q <= ref_s;
      first_q    <= first_d;
      run_q      <= run_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      req_q <= 1'b0;
    end else if (res_we) begin
      res_q <= res_d;
      req_q <= ~req_q;
    end
  end

  assign req_tgl_o = req_q;
  assign cnt_o     = res_q;
endmodule

// File: rtl/freqchk_eval.sv
`timescale 1ns/1ps
// Reference-domain side: receives counts, forms verdicts, runs the timeout.
module freqchk_eval
  import freqchk_pkg::*;
#(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned TMO   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             gated_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic             req_tgl_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             act_o,
  output logic             ack_tgl_o,
  output verdict_t         verdict_o
);
  localparam int unsigned TMO_W = (TMO > 2) ? $clog2(TMO) : 1;
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO - 1);

  logic             act_q, act_d;
  logic             req_s, req_seen_q;
  logic             armed_q, armed_d;
  logic [TMO_W-1:0] tmo_q, tmo_d;
  logic             arrive, tmo_hit, judge;

  freqchk_sync #(.WIDTH(1), .STAGES(2)) u_req_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (req_tgl_i),
    .q_o    (req_s)
  );

  always_comb begin
    act_d   = en_i & ~gated_i;
    arrive  = req_s ^ req_seen_q;
    tmo_hit = act_q && !arrive && (tmo_q == TMO_LAST);
    judge   = arrive && armed_q && act_q;
    armed_d = act_q ? (armed_q | arrive) : 1'b0;
    tmo_d   = (!act_q || arrive || tmo_hit) ? '0 : tmo_q + 1'b1;

    verdict_o.slow = (judge && (cnt_i < lo_i)) || tmo_hit;
    verdict_o.fast = judge && (cnt_i > hi_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q      <= 1'b0;
      req_seen_q <= 1'b0;
      armed_q    <= 1'b0;
      tmo_q      <= '0;
    end else begin
      act_q      <= act_d;
      req_seen_q <= req_s;
      armed_q    <= armed_d;
      tmo_q      <= tmo_d;
    end
  end

  assign act_o     = act_q;
  assign ack_tgl_o = req_seen_q;
endmodule

// File: rtl/freqchk_regs.sv
`timescale 1ns/1ps
module freqchk_regs
  import freqchk_pkg::*;
#(
  parameter int unsigned N_CLK = 3,
  parameter int unsigned CNT_W = 10
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic [N_CLK-1:0]            slow_set_i,
  input  logic [N_CLK-1:0]            fast_set_i,
  output logic [DATA_W-1:0]           rdata_o,
  output logic [N_CLK-1:0]            en_o,
  output logic [N_CLK-1:0][CNT_W-1:0] lo_o,
  output logic [N_CLK-1:0][CNT_W-1:0] hi_o,
  output logic                        lock_o,
  output logic [2*N_CLK-1:0]          err_o
);
  localparam int unsigned ERR_W = 2 * N_CLK;

  logic                        en_we, lock_we, err_we, ctrl_open;
  logic [N_CLK-1:0]            thr_we;
  logic [N_CLK-1:0]            en_q, en_d;
  logic                        lock_q, lock_d;
  logic [ERR_W-1:0]            err_q, err_d, err_set, err_clr;
  logic [N_CLK-1:0][CNT_W-1:0] lo_q, hi_q;
  logic [CNT_W-1:0]            lo_d, hi_d;
  logic                        wdata_unused;

  assign wdata_unused = ^wdata_i;

  // decode
  always_comb begin
    ctrl_open = !lock_q;
    en_we     = wr_en_i && (addr_i == A_EN) && ctrl_open;
    lock_we   = wr_en_i && (addr_i == A_LOCK) && wdata_i[0];
    err_we    = wr_en_i && (addr_i == A_ERR);
    for (int i = 0; i < N_CLK; i++)
      thr_we[i] = wr_en_i && ctrl_open && (int'(addr_i) == THR_BASE + i);
  end

  // next state
  always_comb begin
    en_d   = wdata_i[N_CLK-1:0];
    lo_d   = wdata_i[CNT_W-1:0];
    hi_d   = wdata_i[HI_LSB +: CNT_W];
    lock_d = lock_q | lock_we;
    for (int i = 0; i < N_CLK; i++) begin
      err_set[2*i]   = slow_set_i[i];
      err_set[2*i+1] = fast_set_i[i];
    end
    err_clr = err_we ? wdata_i[ERR_W-1:0] : '0;
    err_d   = (err_q & ~err_clr) | err_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      lock_q <= 1'b0;
      err_q  <= '0;
    end else begin
      if (en_we) en_q <= en_d;
      lock_q <= lock_d;
      err_q  <= err_d;
    end
  end

  for (genvar g = 0; g < N_CLK; g++) begin : g_thr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q[g] <= '0;
        hi_q[g] <= '1;
      end else if (thr_we[g]) begin
        lo_q[g] <= lo_d;
        hi_q[g] <= hi_d;
      end
    end
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_EN:    rdata_o[N_CLK-1:0] = en_q;
      A_LOCK:  rdata_o[0]         = lock_q;
      A_ERR:   rdata_o[ERR_W-1:0] = err_q;
      default: begin
        for (int i = 0; i < N_CLK; i++) begin
          if (int'(addr_i) == THR_BASE + i) begin
            rdata_o[CNT_W-1:0]        = lo_q[i];
            rdata_o[HI_LSB +: CNT_W] = hi_q[i];
          end
        end
      end
    endcase
  end

  assign en_o   = en_q;
  assign lo_o   = lo_q;
  assign hi_o   = hi_q;
  assign lock_o = lock_q;
  assign err_o  = err_q;
endmodule

// File: rtl/freqchk_top.sv
`timescale 1ns/1ps
module freqchk_top
  import freqchk_pkg::*;
#(
  parameter int unsigned N_CLK = 3,
  parameter int unsigned CNT_W = 10,
  parameter int unsigned TMO   = 16
) (
  input  logic               clk_aon_i,
  input  logic               rst_aon_ni,
  input  logic [N_CLK-1:0]   clk_meas_i,
  input  logic [N_CLK-1:0]   rst_meas_ni,
  input  logic [N_CLK-1:0]   gated_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [2*N_CLK-1:0] err_o
);
  logic                        rst_aon_sn;
  logic                        ref_tgl_q;
  logic                        lock_w;
  logic [N_CLK-1:0]            en_w;
  logic [N_CLK-1:0][CNT_W-1:0] lo_w, hi_w;
  logic [N_CLK-1:0]            vslow_w, vfast_w;

  freqchk_rstsync u_rst_aon (
    .clk_i  (clk_aon_i),
    .rst_ni (rst_aon_ni),
    .rst_no (rst_aon_sn)
  );

  // reference toggle: each edge marks one reference period
  always_ff @(posedge clk_aon_i or negedge rst_aon_sn) begin
    if (!rst_aon_sn) ref_tgl_q <= 1'b0;
    else             ref_tgl_q <= ~ref_tgl_q;
  end

  freqchk_regs #(.N_CLK(N_CLK), .CNT_W(CNT_W)) u_regs (
    .clk_i      (clk_aon_i),
    .rst_ni     (rst_aon_sn),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .slow_set_i (vslow_w),
    .fast_set_i (vfast_w),
    .rdata_o    (rdata_o),
    .en_o       (en_w),
    .lo_o       (lo_w),
    .hi_o       (hi_w),
    .lock_o     (lock_w),
    .err_o      (err_o)
  );

  for (genvar g = 0; g < N_CLK; g++) begin : g_chan
    logic             rst_m_sn;
    logic             act, ack_tgl, req_tgl;
    logic [CNT_W-1:0] cnt;
    verdict_t         vd;

    freqchk_rstsync u_rst_m (
      .clk_i  (clk_meas_i[g]),
      .rst_ni (rst_meas_ni[g]),
      .rst_no (rst_m_sn)
    );

    freqchk_meas #(.CNT_W(CNT_W)) u_meas (
      .clk_i     (clk_meas_i[g]),
      .rst_ni    (rst_m_sn),
      .ref_tgl_i (ref_tgl_q),
      .act_i     (act),
      .ack_tgl_i (ack_tgl),
      .req_tgl_o (req_tgl),
      .cnt_o     (cnt)
    );

    freqchk_eval #(.CNT_W(CNT_W), .TMO(TMO)) u_eval (
      .clk_i     (clk_aon_i),
      .rst_ni    (rst_aon_sn),
      .en_i      (en_w[g]),
      .gated_i   (gated_i[g]),
      .lo_i      (lo_w[g]),
      .hi_i      (hi_w[g]),
      .req_tgl_i (req_tgl),
      .cnt_i     (cnt),
      .act_o     (act),
      .ack_tgl_o (ack_tgl),
      .verdict_o (vd)
    );

    assign vslow_w[g] = vd.slow;
    assign vfast_w[g] = vd.fast;
  end
endmodule

// File: rtl/freqchk_chk.sv
`timescale 1ns/1ps
module freqchk_chk
  import freqchk_pkg::*;
#(
  parameter int unsigned N_CLK = 3,
  parameter int unsigned CNT_W = 10
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        wr_en_i,
  input logic [ADDR_W-1:0]           addr_i,
  input logic [DATA_W-1:0]           wdata_i,
  input logic [N_CLK-1:0]            gated_i,
  input logic [2*N_CLK-1:0]          err_i,
  input logic                        lock_i,
  input logic [N_CLK-1:0]            en_i,
  input logic [N_CLK-1:0][CNT_W-1:0] lo_i,
  input logic [N_CLK-1:0][CNT_W-1:0] hi_i,
  input logic [N_CLK-1:0]            slow_i,
  input logic [N_CLK-1:0]            fast_i
);
  assert_lock_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> lock_i);

  assert_ctrl_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> ($stable(en_i) && $stable(lo_i) && $stable(hi_i)));

  for (genvar b = 0; b < 2 * N_CLK; b++) begin : g_bit
    assert_err_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_i[b] && !(wr_en_i && (addr_i == A_ERR) && wdata_i[b])) |=> err_i[b]);
  end

  for (genvar c = 0; c < N_CLK; c++) begin : g_clk
    assert_slow_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slow_i[c] |=> err_i[2*c]);
    assert_fast_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fast_i[c] |=> err_i[2*c+1]);
    assert_gated_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(gated_i[c]) |-> (!slow_i[c] && !fast_i[c]));
    assert_disabled_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(en_i[c]) |-> (!slow_i[c] && !fast_i[c]));
  end
endmodule

bind freqchk_top freqchk_chk #(.N_CLK(N_CLK), .CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_aon_i),
  .rst_ni  (rst_aon_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .gated_i (gated_i),
  .err_i   (err_o),
  .lock_i  (lock_w),
  .en_i    (en_w),
  .lo_i    (lo_w),
  .hi_i    (hi_w),
  .slow_i  (vslow_w),
  .fast_i  (vfast_w)
);

// File: tb/sim_freqchk_top.sv
`timescale 1ns/1ps
module sim_freqchk_top;
  localparam int N = 3;

  logic        clk_aon;
  logic        rst_n;
  logic        c0, c1, c2;
  logic [N-1:0] clk_m;
  logic [N-1:0] gated;
  logic        wr_en;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [2*N-1:0] err;

  real hp0 = 0.25, hp1 = 0.5, hp2 = 0.125;
  logic run0 = 1'b1, run1 = 1'b1, run2 = 1'b1;

  int n_chk = 0;
  int n_fail = 0;
  logic cmp_on = 1'b0;
  logic quiet  = 1'b1;
  logic done   = 1'b0;

  // behavioural register model
  logic [N-1:0]     m_en;
  logic             m_lock;
  logic [2*N-1:0]   m_err;
  logic [9:0]       m_lo [N];
  logic [9:0]       m_hi [N];

  assign clk_m = {c2, c1, c0};

  freqchk_top u0 (
    .clk_aon_i   (clk_aon),
    .rst_aon_ni  (rst_n),
    .clk_meas_i  (clk_m),
    .rst_meas_ni ({N{rst_n}}),
    .gated_i     (gated),
    .wr_en_i     (wr_en),
    .addr_i      (addr),
    .wdata_i     (wdata),
    .rdata_o     (rdata),
    .err_o       (err)
  );

  initial begin clk_aon = 1'b0; forever #4 clk_aon = ~clk_aon; end
  initial begin c0 = 1'b0; #0.1;  forever begin #(hp0); if (run0) c0 = ~c0; end end
  initial begin c1 = 1'b0; #0.07; forever begin #(hp1); if (run1) c1 = ~c1; end end
  initial begin c2 = 1'b0; #0.03; forever begin #(hp2); if (run2) c2 = ~c2; end end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [3:0] a);
    logic [31:0] v;
    v = '0;
    case (a)
      4'd0: v[N-1:0] = m_en;
      4'd1: v[0] = m_lock;
      4'd2: v[2*N-1:0] = m_err;
      4'd4, 4'd5, 4'd6: begin
        v[9:0]   = m_lo[a-4];
        v[25:16] = m_hi[a-4];
      end
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic logic [31:0] thr(input int lo, input int hi);
    return {6'b0, 10'(hi), 6'b0, 10'(lo)};
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_aon);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk_aon);
    #0.1;
    if (a == 4'd0 && !m_lock) m_en = d[N-1:0];
    if (a == 4'd1 && d[0]) m_lock = 1'b1;
    if (a == 4'd2) m_err = m_err & ~d[2*N-1:0];
    if (a >= 4'd4 && a < 4'd7 && !m_lock) begin
      m_lo[a-4] = d[9:0];
      m_hi[a-4] = d[25:16];
    end
    @(negedge clk_aon);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input string tag);
    @(negedge clk_aon);
    addr = a;
    #1;
    check(tag, rdata, exp_rd(a));
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk_aon);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_aon) begin
    #1;
    if (rst_n && cmp_on && !done) begin
      if (addr != 4'd2 || quiet) check("R11 per-cycle readback", rdata, exp_rd(addr));
      if (quiet) check("R2/R8 per-cycle err_o", {26'b0, err}, {26'b0, m_err});
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk_aon);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=expired expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; gated = '0; wr_en = 1'b0; addr = '0; wdata = '0;
    m_en = '0; m_lock = 1'b0; m_err = '0;
    for (int i = 0; i < N; i++) begin m_lo[i] = 10'd0; m_hi[i] = 10'h3FF; end
    wait_cyc(5);
    @(negedge clk_aon);
    rst_n = 1'b1;
    wait_cyc(3);

    // R1 reset state
    rd_chk(4'd0, "R1 enable reset");
    rd_chk(4'd1, "R1 lock reset");
    rd_chk(4'd2, "R1 error reset");
    rd_chk(4'd4, "R1 bound reset");
    check("R1 err_o reset", {26'b0, err}, 32'd0);
    cmp_on = 1'b1;

    // R11 program bounds: nominal 16, 8, 32 with +-4
    wr(4'd4, thr(12, 20));
    wr(4'd5, thr(4, 12));
    wr(4'd6, thr(28, 36));
    rd_chk(4'd5, "R11 bound readback");
    rd_chk(4'd7, "R11 unused address");
    wr(4'd0, 32'h7);
    rd_chk(4'd0, "R11 enable readback");
    wait_cyc(60);
    check("R2 R6 no error in range after enable", {26'b0, err}, 32'd0);

    // R3 fast on clock 1
    quiet = 1'b0;
    hp1 = 0.25;
    wait_cyc(30);
    check("R3 fast flag clk1", {31'b0, err[3]}, 32'd1);
    check("R3 slow flag clk1 untouched", {31'b0, err[2]}, 32'd0);
    hp1 = 0.5;
    wait_cyc(25);
    check("R5 fast flag sticky", {31'b0, err[3]}, 32'd1);
    wr(4'd2, 32'h0);
    check("R5 write zero keeps flag", {31'b0, err[3]}, 32'd1);
    wr(4'd2, 32'hFFFF_FFFF);
    m_err = '0;
    quiet = 1'b1;
    wait_cyc(40);
    check("R5 cleared stays clear", {26'b0, err}, 32'd0);

    // R4 slow on clock 2 by raising the bounds
    quiet = 1'b0;
    wr(4'd6, thr(40, 50));
    wait_cyc(30);
    check("R4 slow flag clk2", {31'b0, err[4]}, 32'd1);
    check("R4 fast flag clk2 clear", {31'b0, err[5]}, 32'd0);
    wr(4'd6, thr(28, 36));
    wait_cyc(20);
    wr(4'd2, 32'h3F);
    m_err = '0;
    quiet = 1'b1;
    wait_cyc(30);
    check("R4 R5 clean after restore", {26'b0, err}, 32'd0);

    // R7 timeout on a stopped, enabled, ungated clock 0
    quiet = 1'b0;
    run0 = 1'b0;
    wait_cyc(40);
    check("R7 timeout sets slow clk0", {31'b0, err[0]}, 32'd1);
    check("R7 timeout leaves fast clk0", {31'b0, err[1]}, 32'd0);
    run0 = 1'b1;
    wait_cyc(20);
    wr(4'd2, 32'h3F);
    m_err = '0;
    quiet = 1'b1;
    wait_cyc(40);
    check("R7 restart then clean", {26'b0, err}, 32'd0);

    // R8 gated low-power episode
    @(negedge clk_aon);
    gated = '1;
    wait_cyc(4);
    run0 = 1'b0; run1 = 1'b0; run2 = 1'b0;
    wait_cyc(60);
    check("R8 no error while gated", {26'b0, err}, 32'd0);
    run0 = 1'b1; run1 = 1'b1; run2 = 1'b1;
    wait_cyc(4);
    @(negedge clk_aon);
    gated = '0;
    wait_cyc(60);
    check("R8 R6 no error after ungating", {26'b0, err}, 32'd0);

    // R9 disable, stop, re-enable
    wr(4'd0, 32'h0);
    run0 = 1'b0;
    wait_cyc(40);
    check("R9 disabled stopped clock quiet", {26'b0, err}, 32'd0);
    run0 = 1'b1;
    wait_cyc(4);
    wr(4'd0, 32'h7);
    wait_cyc(60);
    check("R9 R6 re-enable clean", {26'b0, err}, 32'd0);

    // R10 lock
    wr(4'd1, 32'h1);
    rd_chk(4'd1, "R10 lock set");
    wr(4'd0, 32'h0);
    rd_chk(4'd0, "R10 enable frozen");
    wr(4'd4, thr(1, 2));
    rd_chk(4'd4, "R10 bounds frozen");
    quiet = 1'b0;
    hp1 = 0.25;
    wait_cyc(30);
    check("R10 R3 enable still active under lock", {31'b0, err[3]}, 32'd1);
    hp1 = 0.5;
    wait_cyc(25);
    wr(4'd2, 32'h3F);
    m_err = '0;
    quiet = 1'b1;
    wait_cyc(30);
    check("R10 clear works under lock", {26'b0, err}, 32'd0);
    rd_chk(4'd2, "R10 error readback after clear");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule